// File: doc/BRIEF.md
# Software-Raised Interrupt Status Controller

This block keeps a 32-bit word of pending interrupt causes. Software sets bits through a write-only raise register and clears them through a write-only acknowledge register, and bits are cleared only where the written value has a one. The compute and DMA engines next to the block can also set cause bits by presenting a one-cycle pulse together with a bit pattern. Software reads the whole word back at the status offset.

The block drives two outputs, and a mode input chooses between them. In level mode, which is the default with `msiMode` low, a legacy interrupt line stays high for as long as any cause bit is set. In message mode the legacy line stays low. Instead, a one-cycle message request goes out for every raise that carries a non-zero pattern, whether or not the word already held bits. In both modes the cause bits stay set until software acknowledges them.

Top module: `irq_stat_top`

## Requirements
- R1: While reset is held and right after it, the status word is zero, `legacyIrq` is low and `msgPulse` is low.
- R2: With `rdAddr` = 0x24, `rdData` returns the current status word in the same cycle.
- R3: A write to offset 0x60 ORs `wrData` into the status word, and the change is visible in the cycle after the write.
- R4: A write to offset 0x64 clears every status bit that is set in `wrData`, and leaves all other bits as they were.
- R5: When a raise and an acknowledge happen in the same cycle, the new status is (status & ~ack) | raise.
- R6: A pulse on `srcPulse[i]` ORs slice i of `srcBits` (bits 32*i+31 down to 32*i) into the status word. Several sources may pulse in the same cycle.
- R7: With `msiMode` low, `legacyIrq` is high exactly when the status word is non-zero, and `msgPulse` stays low.
- R8: With `msiMode` high, `legacyIrq` stays low. `msgPulse` is high for exactly the one cycle after each cycle whose combined raise value is non-zero, even if those bits were already set.
- R9: Reads of offsets 0x60, 0x64 and any other offset except 0x24 return zero.
- R10: Writes to offset 0x24 or to any unmapped offset leave the status word unchanged.
- R11: In message mode the status bits stay set across idle cycles until an acknowledge clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| msiMode | input | 1 | 0: level line, 1: message pulses |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 8 | Byte offset of the write |
| wrData | input | 32 | Write data |
| rdAddr | input | 8 | Byte offset of the read |
| rdData | output | 32 | Read data (combinational) |
| srcPulse | input | 2 | Internal raise pulses, one per source |
| srcBits | input | 64 | Raise patterns, 32 bits per source |
| legacyIrq | output | 1 | Level interrupt line |
| msgPulse | output | 1 | One-cycle message request |

## Verification
A wrong status bit shows up in `rdData` in the first cycle after the faulty edge, provided the status offset is being read. In level mode it also shows up on `legacyIrq` in that same cycle whenever the whole word goes to or from zero. A lost or duplicated message request shows up on `msgPulse` exactly one cycle after the raise. The scoreboard therefore compares all three outputs in every cycle and does not wait for a later read.

// File: rtl/irq_stat_pkg.sv
package irq_stat_pkg;
  typedef struct packed {
    logic setEn;   // combined raise value is non-zero
    logic clrEn;   // acknowledge write this cycle
    logic msgReq;  // a message must follow this raise
  } irqStrobeT;
endpackage

// File: rtl/irq_stat_ctrl.sv
module irq_stat_ctrl
  import irq_stat_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned NUM_SRC   = 2,
  parameter logic [ADDR_W-1:0] RAISE_OFF = 8'h60,
  parameter logic [ADDR_W-1:0] ACK_OFF   = 8'h64
) (
  input  logic                      msiMode,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         wrAddr,
  input  logic [DATA_W-1:0]         wrData,
  input  logic [NUM_SRC-1:0]        srcPulse,
  input  logic [NUM_SRC*DATA_W-1:0] srcBits,
  output irqStrobeT                 strb,
  output logic [DATA_W-1:0]         setVal,
  output logic [DATA_W-1:0]         clrVal
);
  logic swRaise, swAck;
  logic [DATA_W-1:0] srcAcc [NUM_SRC+1];

  assign swRaise = wrEn && (wrAddr == RAISE_OFF);
  assign swAck   = wrEn && (wrAddr == ACK_OFF);

  // Fold internal raise sources into one pattern.
  assign srcAcc[0] = swRaise ? wrData : '0;
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign srcAcc[i+1] = srcAcc[i] |
      (srcPulse[i] ? srcBits[i*DATA_W +: DATA_W] : '0);
  end

  assign setVal      = srcAcc[NUM_SRC];
  assign clrVal      = swAck ? wrData : '0;
  assign strb.setEn  = |setVal;
  assign strb.clrEn  = swAck;
  assign strb.msgReq = msiMode && strb.setEn;
endmodule

// File: rtl/irq_stat_dp.sv
module irq_stat_dp
  import irq_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_OFF = 8'h24
) (
  input  logic              clk,
  input  logic              rstN,
  input  irqStrobeT         strb,
  input  logic [DATA_W-1:0] setVal,
  input  logic [DATA_W-1:0] clrVal,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] statusQ
);
  always_ff @(posedge clk) begin
    if (!rstN)
      statusQ <= '0;
    else if (strb.setEn || strb.clrEn)
      statusQ <= (statusQ & ~clrVal) | setVal;
  end

  assign rdData = (rdAddr == STATUS_OFF) ? statusQ : '0;

  AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rstN)
    strb.setEn |=> ((statusQ & $past(setVal)) == $past(setVal))); // R3
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.clrEn |=> ((statusQ & $past(clrVal) & ~$past(setVal)) == '0)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.setEn && !strb.clrEn) |=> $stable(statusQ)); // R11
  AST_MSG_NEEDS_SET: assert property (@(posedge clk) disable iff (!rstN)
    strb.msgReq |-> strb.setEn); // R8
endmodule

// File: rtl/irq_stat_out.sv
module irq_stat_out
  import irq_stat_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              msiMode,
  input  irqStrobeT         strb,
  input  logic [DATA_W-1:0] statusQ,
  output logic              legacyIrq,
  output logic              msgPulse
);
  logic unusedStrb;
  assign unusedStrb = strb.setEn ^ strb.clrEn;

  always_ff @(posedge clk) begin
    if (!rstN) msgPulse <= 1'b0;
    else       msgPulse <= strb.msgReq;
  end

  assign legacyIrq = !msiMode && (|statusQ);

  AST_MSG_ONE_SHOT: assert property (@(posedge clk) disable iff (!rstN)
    (msgPulse && !strb.msgReq) |=> !msgPulse); // R8
endmodule

// File: rtl/irq_stat_top.sv
module irq_stat_top
  import irq_stat_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned NUM_SRC = 2,
  parameter logic [ADDR_W-1:0] STATUS_OFF = 8'h24,
  parameter logic [ADDR_W-1:0] RAISE_OFF  = 8'h60,
  parameter logic [ADDR_W-1:0] ACK_OFF    = 8'h64
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      msiMode,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         wrAddr,
  input  logic [DATA_W-1:0]         wrData,
  input  logic [ADDR_W-1:0]         rdAddr,
  output logic [DATA_W-1:0]         rdData,
  input  logic [NUM_SRC-1:0]        srcPulse,
  input  logic [NUM_SRC*DATA_W-1:0] srcBits,
  output logic                      legacyIrq,
  output logic                      msgPulse
);
  irqStrobeT strb;
  logic [DATA_W-1:0] setVal, clrVal, statusQ;

  irq_stat_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_SRC(NUM_SRC),
                  .RAISE_OFF(RAISE_OFF), .ACK_OFF(ACK_OFF)) ctrl_i (
    .msiMode(msiMode), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .srcPulse(srcPulse), .srcBits(srcBits),
    .strb(strb), .setVal(setVal), .clrVal(clrVal));

  irq_stat_dp #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .STATUS_OFF(STATUS_OFF)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .setVal(setVal), .clrVal(clrVal),
    .rdAddr(rdAddr), .rdData(rdData), .statusQ(statusQ));

  irq_stat_out #(.DATA_W(DATA_W)) out_i (
    .clk(clk), .rstN(rstN), .msiMode(msiMode), .strb(strb),
    .statusQ(statusQ), .legacyIrq(legacyIrq), .msgPulse(msgPulse));

  AST_LEVEL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    legacyIrq |-> (statusQ != '0)); // R7
  AST_MSG_FOLLOWS_RAISE: assert property (@(posedge clk) disable iff (!rstN)
    msgPulse |-> $past(strb.setEn)); // R8
endmodule

// File: tb/irq_stat_top_tb_top.sv
module irq_stat_top_tb_top;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic msiMode = 1'b0, wrEn = 1'b0;
  logic [7:0] wrAddr = '0, rdAddr = 8'h24;
  logic [W-1:0] wrData = '0, rdData;
  logic [1:0] srcPulse = '0;
  logic [2*W-1:0] srcBits = '0;
  logic legacyIrq, msgPulse;

  irq_stat_top dut_i (.clk(clk), .rstN(rstN), .msiMode(msiMode), .wrEn(wrEn),
    .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr), .rdData(rdData),
    .srcPulse(srcPulse), .srcBits(srcBits), .legacyIrq(legacyIrq),
    .msgPulse(msgPulse));

  always #2 clk = ~clk;

  typedef struct {
    logic [W-1:0] rd;
    logic lvl;
    logic msg;
    string tag;
  } expT;

  expT q[$];
  int errors = 0, checks = 0;
  logic [W-1:0] mStat = '0;
  logic mMsg = 1'b0;
  bit driverDone = 0;

  // Apply one cycle of stimulus; queue the outputs expected in this cycle,
  // then advance the model across the closing edge.
  task automatic step(input logic msi, input logic we, input logic [7:0] wa,
                      input logic [W-1:0] wd, input logic [7:0] ra,
                      input logic [1:0] sp, input logic [W-1:0] b0,
                      input logic [W-1:0] b1, input string tag);
    expT e;
    logic [W-1:0] setV, clrV;
    @(posedge clk); #1;
    msiMode = msi; wrEn = we; wrAddr = wa; wrData = wd; rdAddr = ra;
    srcPulse = sp; srcBits = {b1, b0};
    e.rd  = (ra == 8'h24) ? mStat : '0;
    e.lvl = !msi && (mStat != '0);
    e.msg = mMsg;
    e.tag = tag;
    q.push_back(e);
    setV = ((we && wa == 8'h60) ? wd : '0) | (sp[0] ? b0 : '0) | (sp[1] ? b1 : '0);
    clrV = (we && wa == 8'h64) ? wd : '0;
    mStat = (mStat & ~clrV) | setV;
    mMsg  = msi && (setV != '0);
  endtask

  task automatic idle(input logic msi, input string tag);
    step(msi, 0, 8'h00, '0, 8'h24, 2'b00, '0, '0, tag);
  endtask

  // Monitor: compare queued expectations at each falling edge.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        expT e;
        e = q.pop_front();
        checks++;
        if (rdData !== e.rd || legacyIrq !== e.lvl || msgPulse !== e.msg) begin
          errors++;
          $display("FAIL %s: rd=%h lvl=%b msg=%b expected rd=%h lvl=%b msg=%b",
                   e.tag, rdData, legacyIrq, msgPulse, e.rd, e.lvl, e.msg);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (rdData !== '0 || legacyIrq !== 1'b0 || msgPulse !== 1'b0) begin
      errors++;
      $display("FAIL R1: rd=%h lvl=%b msg=%b expected rd=0 lvl=0 msg=0",
               rdData, legacyIrq, msgPulse);
    end
    @(posedge clk); #1 rstN = 1'b1;
    idle(0, "R1 after reset");
    // level mode raises
    step(0, 1, 8'h60, 32'h5, 8'h24, 2'b00, '0, '0, "R3 raise 5");
    idle(0, "R3 R7 status 5, line high");
    step(0, 1, 8'h60, 32'h30, 8'h24, 2'b00, '0, '0, "R3 raise 30");
    idle(0, "R2 R3 status 35");
    step(0, 0, 8'h00, '0, 8'h60, 2'b00, '0, '0, "R9 read raise offset");
    step(0, 0, 8'h00, '0, 8'h64, 2'b00, '0, '0, "R9 read ack offset");
    step(0, 0, 8'h00, '0, 8'h00, 2'b00, '0, '0, "R9 read unmapped");
    step(0, 1, 8'h24, 32'hFFFF_FFFF, 8'h24, 2'b00, '0, '0, "R10 write status offset");
    step(0, 1, 8'h40, 32'hFFFF_FFFF, 8'h24, 2'b00, '0, '0, "R10 write unmapped");
    idle(0, "R10 status unchanged");
    step(0, 1, 8'h64, 32'h4, 8'h24, 2'b00, '0, '0, "R4 ack 4");
    idle(0, "R4 status 31");
    step(0, 1, 8'h64, 32'h31, 8'h24, 2'b00, '0, '0, "R4 ack rest");
    idle(0, "R4 R7 status 0, line low");
    // internal sources
    step(0, 0, 8'h00, '0, 8'h24, 2'b01, 32'h100, 32'hDEAD, "R6 src0");
    idle(0, "R6 status 100");
    step(0, 0, 8'h00, '0, 8'h24, 2'b11, 32'h1, 32'h1000, "R6 both sources");
    idle(0, "R6 status 1101");
    step(0, 1, 8'h64, 32'h101, 8'h24, 2'b01, 32'h100, '0, "R5 ack with raise");
    idle(0, "R5 status 1100");
    step(0, 1, 8'h64, 32'hFFFF_FFFF, 8'h24, 2'b10, '0, 32'h8000_0000, "R5 ack all plus raise");
    idle(0, "R5 status 80000000");
    step(0, 1, 8'h64, 32'hFFFF_FFFF, 8'h24, 2'b00, '0, '0, "R4 clear");
    // message mode
    idle(1, "R8 enter msg mode");
    step(1, 1, 8'h60, 32'h8, 8'h24, 2'b00, '0, '0, "R8 raise 8");
    idle(1, "R8 pulse, line low");
    idle(1, "R8 pulse one cycle");
    step(1, 1, 8'h60, 32'h8, 8'h24, 2'b00, '0, '0, "R8 re-raise same bit");
    idle(1, "R8 second pulse");
    step(1, 1, 8'h60, 32'h0, 8'h24, 2'b00, '0, '0, "R8 zero raise");
    idle(1, "R8 no pulse for zero raise");
    step(1, 0, 8'h00, '0, 8'h24, 2'b01, 32'h2, '0, "R8 internal raise");
    step(1, 0, 8'h00, '0, 8'h24, 2'b01, 32'h4, '0, "R8 back-to-back raise");
    idle(1, "R8 pulse held");
    for (int i = 0; i < 4; i++) idle(1, "R11 status held");
    step(1, 1, 8'h64, 32'hE, 8'h24, 2'b00, '0, '0, "R11 ack in msg mode");
    idle(1, "R11 status cleared");
    step(1, 1, 8'h60, 32'h40, 8'h24, 2'b00, '0, '0, "R8 raise before mode switch");
    idle(0, "R7 level line returns");
    idle(0, "R7 level line held");
    @(posedge clk); #1 wrEn = 1'b0;
    repeat (3) @(posedge clk);
    driverDone = 1;
  end

  initial begin
    fork
      begin wait (driverDone); end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule